// File: doc/BRIEF.md
# I2C Channel-Select Controller

This block is the digital half of a one-of-four bus fan-out. It sits on a host I2C bus as a target device. The host addresses it and writes one control byte, which picks at most one of four downstream channels. The block drives a one-hot connect vector that an external switch fabric uses to join the host bus lines to the chosen channel. The host can also read the byte back. The read byte carries the live state of the four per-channel interrupt inputs along with the stored selection.

SCL and SDA are oversampled with the system clock. Each line passes through a synchronizer and a three-tap majority filter before any edge is decoded. The block acknowledges by enabling an open-drain pull-down on SDA. A new selection is held back and reaches the connect vector only when the host closes the transaction with a STOP. The downstream lines are therefore never joined in the middle of a transfer.

Top module: `chansel_top`

## Requirements
- R1: The block acknowledges (drives `sdaOe` high through the ninth clock) an address byte whose upper seven bits equal binary 1110 followed by `strap[2:0]`. The last bit of the address byte selects a read when it is 1 and a write when it is 0.
- R2: After an address that does not match, the block drives no acknowledge and ignores all further bytes until the next START or STOP. The stored selection and the connect vector are unchanged.
- R3: In a write, every data byte after the address is acknowledged, and the last byte before the STOP is the one kept.
- R4: Control byte encoding: bit 2 enables a connection, bits 1:0 give the channel index, and bit 3 is ignored. `chanConnect` is all zero when bit 2 is 0 and otherwise has exactly bit `index` set. It never has more than one bit set.
- R5: `chanConnect` changes only after a STOP (SDA rising while SCL is high). It keeps its old value while the write is in progress.
- R6: A repeated START restarts address reception and does not apply a pending selection. The following read already returns the new stored bits.
- R7: A read returns the byte {~irqN[3:0], 0, stored bits 2:0}. A bit in 7:4 is 1 when that channel's active-low interrupt input is low. If the host acknowledges, the byte is sent again.
- R8: Synchronous reset clears the stored selection to zero, disconnects every channel, releases SDA and returns the bus logic to idle.
- R9: A pulse on SDA that lasts one system clock is filtered out. It is not decoded as a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | Level of the host SCL line |
| sdaIn | input | 1 | Level of the host SDA line |
| strap | input | 3 | Strap inputs forming the low address bits |
| irqN | input | 4 | Active-low interrupt input of each channel |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| chanConnect | output | 4 | One-hot channel connect vector |

## Verification
The bench looks first at when a selection takes effect. A design that applies a written byte at the acknowledge, or at a repeated START, would switch the connect vector early, and the per-clock model comparison catches that. A mismatched address followed by a data byte and a STOP tests that the ignore state really discards the data. A design that kept listening would acknowledge or store that byte. Other cases are: back-to-back data bytes where only the last one counts, bit 3 set with the enable bit, a disable write, a host-acknowledged read that must repeat the byte, and a one-cycle SDA pulse during SCL high. An unfiltered design would decode that pulse as a START and STOP pair and connect the pending channel.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } busState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;
    logic storeCfg;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
    logic applySel;
  } strobes_t;

endpackage

// File: rtl/chansel_busfront.sv
module chansel_busfront #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int LINES = 2;
  localparam int VOTE_MAJ = VOTE_TAPS / 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv;

  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncQ;
    logic [VOTE_TAPS-1:0]   voteQ;
    logic                   filtQ;
    logic                   prevQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '1;
        voteQ <= '1;
        filtQ <= 1'b1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn[g]};
        voteQ <= {voteQ[VOTE_TAPS-2:0], syncQ[SYNC_STAGES-1]};
        filtQ <= ($countones(voteQ) > VOTE_MAJ);
        prevQ <= filtQ;
      end
    end

    assign lvl[g] = filtQ;
    assign prv[g] = prevQ;
  end

  // bit 0 is SCL, bit 1 is SDA
  assign sdaLvl  = lvl[1];
  assign sclRise = lvl[0] & ~prv[0];
  assign sclFall = ~lvl[0] & prv[0];
  assign startEv = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stopEv  = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/chansel_ctrl.sv
module chansel_ctrl
  import chansel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     startEv,
  input  logic     stopEv,
  input  logic     sdaLvl,
  input  logic     addrHit,
  input  logic     rwBit,
  output strobes_t strb,
  output logic     inIgnore
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

  busState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             rwQ, rwD;
  logic             nackQ, nackD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    rwD    = rwQ;
    nackD  = nackQ;
    strb   = '0;
    if (stopEv) begin
      stateD          = S_IDLE;
      strb.applySel   = 1'b1;
      strb.releaseSda = 1'b1;
    end else if (startEv) begin
      stateD          = S_ADDR;
      cntD            = '0;
      strb.releaseSda = 1'b1;
    end else begin
      case (stateQ)
        S_ADDR, S_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            cntD         = cntQ + 1'b1;
          end else if (sclFall && cntQ == FULL_CNT) begin
            if (stateQ == S_ADDR) begin
              if (addrHit) begin
                stateD        = S_ADDR_ACK;
                rwD           = rwBit;
                strb.driveAck = 1'b1;
              end else begin
                stateD = S_IGNORE;
              end
            end else begin
              stateD        = S_WACK;
              strb.storeCfg = 1'b1;
              strb.driveAck = 1'b1;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            cntD = '0;
            if (rwQ) begin
              stateD      = S_RDATA;
              strb.loadTx = 1'b1;
            end else begin
              stateD          = S_WDATA;
              strb.releaseSda = 1'b1;
            end
          end
        end
        S_WACK: begin
          if (sclFall) begin
            stateD          = S_WDATA;
            cntD            = '0;
            strb.releaseSda = 1'b1;
          end
        end
        S_RDATA: begin
          if (sclRise) begin
            cntD = cntQ + 1'b1;
          end else if (sclFall) begin
            if (cntQ == FULL_CNT) begin
              stateD          = S_RACK;
              strb.releaseSda = 1'b1;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            nackD = sdaLvl;
          end else if (sclFall) begin
            if (nackQ) begin
              stateD = S_IGNORE;
            end else begin
              stateD      = S_RDATA;
              cntD        = '0;
              strb.loadTx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      rwQ    <= 1'b0;
      nackQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      rwQ    <= rwD;
      nackQ  <= nackD;
    end
  end

  assign inIgnore = (stateQ == S_IGNORE);

  // the acknowledge phase is only ever reached with a matching address
  assert_ack_on_match_R1: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_ADDR_ACK) |-> addrHit);

endmodule

// File: rtl/chansel_datapath.sv
module chansel_datapath
  import chansel_pkg::*;
#(
  parameter int          CH_IDX_W   = 2,
  parameter int          STRAP_W    = 3,
  parameter logic [3:0]  ADDR_FIXED = 4'b1110
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobes_t                   strb,
  input  logic                       sdaLvl,
  input  logic [STRAP_W-1:0]         strap,
  input  logic [(1<<CH_IDX_W)-1:0]   irqN,
  output logic                       addrHit,
  output logic                       rwBit,
  output logic                       sdaOe,
  output logic [(1<<CH_IDX_W)-1:0]   chanConnect
);
  localparam int NUM_CH = 1 << CH_IDX_W;
  localparam int CFG_W  = CH_IDX_W + 1;
  localparam int PAD_W  = BYTE_BITS - NUM_CH - CFG_W;

  logic [BYTE_BITS-1:0] rxQ;
  logic [BYTE_BITS-1:0] txQ;
  logic [BYTE_BITS-1:0] txByte;
  logic [CFG_W-1:0]     cfgQ;
  logic [NUM_CH-1:0]    irqSync1, irqSync2;
  logic [NUM_CH-1:0]    connD, connQ;
  logic                 oeQ;

  assign addrHit = (rxQ[BYTE_BITS-1:1] == {ADDR_FIXED, strap});
  assign rwBit   = rxQ[0];

  // read byte: active-high interrupt flags, zero pad, stored selection
  assign txByte = {~irqSync2, {PAD_W{1'b0}}, cfgQ};

  for (genvar g = 0; g < NUM_CH; g++) begin : gDecode
    assign connD[g] = cfgQ[CFG_W-1] && (cfgQ[CH_IDX_W-1:0] == CH_IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxQ      <= '0;
      txQ      <= '0;
      cfgQ     <= '0;
      irqSync1 <= '1;
      irqSync2 <= '1;
      connQ    <= '0;
      oeQ      <= 1'b0;
    end else begin
      irqSync1 <= irqN;
      irqSync2 <= irqSync1;
      if (strb.shiftIn)  rxQ  <= {rxQ[BYTE_BITS-2:0], sdaLvl};
      if (strb.storeCfg) cfgQ <= rxQ[CFG_W-1:0];
      if (strb.loadTx)       txQ <= txByte;
      else if (strb.shiftTx) txQ <= {txQ[BYTE_BITS-2:0], 1'b0};
      if (strb.releaseSda)    oeQ <= 1'b0;
      else if (strb.driveAck) oeQ <= 1'b1;
      else if (strb.loadTx)   oeQ <= ~txByte[BYTE_BITS-1];
      else if (strb.shiftTx)  oeQ <= ~txQ[BYTE_BITS-2];
      if (strb.applySel) connQ <= connD;
    end
  end

  assign sdaOe       = oeQ;
  assign chanConnect = connQ;

  assert_single_channel_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(connQ));

endmodule

// File: rtl/chansel_top.sv
module chansel_top
  import chansel_pkg::*;
#(
  parameter int         CH_IDX_W    = 2,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         VOTE_TAPS   = 3,
  parameter logic [3:0] ADDR_FIXED  = 4'b1110
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  logic [STRAP_W-1:0]       strap,
  input  logic [(1<<CH_IDX_W)-1:0] irqN,
  output logic                     sdaOe,
  output logic [(1<<CH_IDX_W)-1:0] chanConnect
);
  strobes_t strb;
  logic sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic addrHit, rwBit, inIgnore;

  chansel_busfront #(
    .SYNC_STAGES(SYNC_STAGES),
    .VOTE_TAPS  (VOTE_TAPS)
  ) u_front (
    .clk    (clk),
    .rst    (rst),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .sdaLvl (sdaLvl),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startEv(startEv),
    .stopEv (stopEv)
  );

  chansel_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startEv (startEv),
    .stopEv  (stopEv),
    .sdaLvl  (sdaLvl),
    .addrHit (addrHit),
    .rwBit   (rwBit),
    .strb    (strb),
    .inIgnore(inIgnore)
  );

  chansel_datapath #(
    .CH_IDX_W  (CH_IDX_W),
    .STRAP_W   (STRAP_W),
    .ADDR_FIXED(ADDR_FIXED)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .sdaLvl     (sdaLvl),
    .strap      (strap),
    .irqN       (irqN),
    .addrHit    (addrHit),
    .rwBit      (rwBit),
    .sdaOe      (sdaOe),
    .chanConnect(chanConnect)
  );

  assert_connect_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (chanConnect != $past(chanConnect)) |-> $past(stopEv));

  assert_quiet_when_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    inIgnore |-> !sdaOe);

  assert_reset_idle_R8: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (chanConnect == '0 && !sdaOe));

endmodule

// File: tb/chansel_top_bench.sv
`timescale 1ns/1ps
module chansel_top_bench;
  localparam int Q      = 20;
  localparam int SETTLE = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [3:0] irqN = 4'b1111;
  logic       sdaOe;
  logic [3:0] chanConnect;
  logic       sdaLine;

  assign sdaLine = sdaDrv & ~sdaOe;

  chansel_top u_chansel_top (
    .clk        (clk),
    .rst        (rst),
    .sclIn      (sclDrv),
    .sdaIn      (sdaLine),
    .strap      (strap),
    .irqN       (irqN),
    .sdaOe      (sdaOe),
    .chanConnect(chanConnect)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEdge = 0;

  // behavioural model state
  logic       expOe = 1'b0, nxtOe = 1'b0;
  logic [3:0] expConn = '0, nxtConn = '0;
  logic [2:0] modelCfg = '0;

  function automatic logic [3:0] connOf(input logic [2:0] c);
    return c[2] ? (4'b0001 << c[1:0]) : 4'b0000;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, outside the settle window
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst && (cyc - lastEdge > SETTLE)) begin
        check(sdaOe == expOe, "R1 sdaOe vs model", int'(sdaOe), int'(expOe));
        check(chanConnect == expConn, "R5 chanConnect vs model",
              int'(chanConnect), int'(expConn));
      end
    end
  end

  task automatic drive(input logic s, input logic d);
    @(posedge clk); #1;
    sclDrv = s; sdaDrv = d;
    expOe = nxtOe; expConn = nxtConn;
    lastEdge = cyc;
    repeat (Q) @(posedge clk);
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rst = 1'b1; sclDrv = 1'b1; sdaDrv = 1'b1;
    nxtOe = 0; nxtConn = '0; expOe = 0; expConn = '0; modelCfg = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    lastEdge = cyc;
    repeat (Q) @(posedge clk);
  endtask

  task automatic busStart();
    nxtOe = 1'b0;
    drive(1, 0);
    drive(0, 0);
  endtask

  task automatic busRepStart();
    drive(0, 1);
    drive(1, 1);
    busStart();
  endtask

  task automatic busStop();
    drive(0, 0);
    drive(1, 0);
    nxtConn = connOf(modelCfg);
    drive(1, 1);
  endtask

  task automatic sendByte(input logic [7:0] data, input logic expAck,
                          input logic oeAfter, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      drive(0, data[i]);
      drive(1, data[i]);
      if (i == 0) nxtOe = expAck;
      drive(0, data[i]);
    end
    drive(0, 1);
    drive(1, 1);
    acked = !sdaLine;
    nxtOe = oeAfter;
    drive(0, 1);
  endtask

  task automatic readByte(input logic [7:0] exp, input logic hostAck,
                          output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      drive(0, 1);
      drive(1, 1);
      got[i] = sdaLine;
      nxtOe = (i > 0) ? ~exp[i-1] : 1'b0;
      drive(0, 1);
    end
    drive(0, ~hostAck);
    drive(1, ~hostAck);
    nxtOe = hostAck ? ~exp[7] : 1'b0;
    drive(0, ~hostAck);
  endtask

  task automatic writeCfg(input logic [7:0] data);
    logic a;
    busStart();
    sendByte(8'hEA, 1, 0, a);
    check(a, "R1 write address ack", int'(a), 1);
    sendByte(data, 1, 0, a);
    check(a, "R3 data ack", int'(a), 1);
    modelCfg = data[2:0];
    busStop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] got;

    doReset();
    check(chanConnect == 4'b0000, "R8 reset connect", int'(chanConnect), 0);
    check(sdaOe == 1'b0, "R8 reset sdaOe", int'(sdaOe), 0);

    // R3/R4: two data bytes, last kept, bit 3 ignored (0x0E -> channel 2)
    busStart();
    sendByte(8'hEA, 1, 0, a);
    check(a, "R1 address ack", int'(a), 1);
    sendByte(8'h04, 1, 0, a);
    check(a, "R3 first data ack", int'(a), 1);
    modelCfg = 3'b100;
    sendByte(8'h0E, 1, 0, a);
    check(a, "R3 second data ack", int'(a), 1);
    modelCfg = 3'b110;
    check(chanConnect == 4'b0000, "R5 no change before stop", int'(chanConnect), 0);
    busStop();
    check(chanConnect == 4'b0100, "R3 R4 last byte applied", int'(chanConnect), 4);

    // R7: read status {~irqN, 0, cfg}
    irqN = 4'b1010;
    busStart();
    sendByte(8'hEB, 1, ~1'b0, a);
    check(a, "R1 read address ack", int'(a), 1);
    readByte(8'h56, 0, got);
    check(got == 8'h56, "R7 read byte", int'(got), 'h56);
    busStop();
    check(chanConnect == 4'b0100, "R7 read leaves connect", int'(chanConnect), 4);

    // R2: mismatched address, following byte ignored
    busStart();
    sendByte(8'hE8, 0, 0, a);
    check(!a, "R2 mismatch no ack", int'(a), 0);
    sendByte(8'h05, 0, 0, a);
    check(!a, "R2 ignored byte no ack", int'(a), 0);
    busStop();
    check(chanConnect == 4'b0100, "R2 connect unchanged", int'(chanConnect), 4);

    // R6: repeated start keeps pending selection, read shows it; host ACK repeats
    irqN = 4'b1111;
    busStart();
    sendByte(8'hEA, 1, 0, a);
    sendByte(8'h05, 1, 0, a);
    check(a, "R3 data ack before repeated start", int'(a), 1);
    modelCfg = 3'b101;
    busRepStart();
    check(chanConnect == 4'b0100, "R6 repeated start no apply", int'(chanConnect), 4);
    sendByte(8'hEB, 1, ~1'b0, a);
    readByte(8'h05, 1, got);
    check(got == 8'h05, "R6 read pending cfg", int'(got), 5);
    readByte(8'h05, 0, got);
    check(got == 8'h05, "R7 repeated read byte", int'(got), 5);
    busStop();
    check(chanConnect == 4'b0010, "R6 applied at stop", int'(chanConnect), 2);

    // R4: disable, then channel 3
    writeCfg(8'h03);
    check(chanConnect == 4'b0000, "R4 disable", int'(chanConnect), 0);
    writeCfg(8'h07);
    check(chanConnect == 4'b1000, "R4 channel 3", int'(chanConnect), 8);

    // R9: one-cycle SDA pulse while SCL high must not act as START/STOP
    busStart();
    sendByte(8'hEA, 1, 0, a);
    sendByte(8'h04, 1, 0, a);
    modelCfg = 3'b100;
    busRepStart();
    sendByte(8'hE0, 0, 0, a);
    check(!a, "R2 mismatch after repeated start", int'(a), 0);
    drive(1, 1);
    @(posedge clk); #1 sdaDrv = 1'b0; lastEdge = cyc;
    @(posedge clk); #1 sdaDrv = 1'b1; lastEdge = cyc;
    repeat (Q) @(posedge clk);
    check(chanConnect == 4'b1000, "R9 glitch filtered", int'(chanConnect), 8);
    drive(0, 1);
    busStop();
    check(chanConnect == 4'b0001, "R5 real stop applies", int'(chanConnect), 1);

    // R8: mid-run reset clears selection and stored bits
    doReset();
    check(chanConnect == 4'b0000, "R8 reset disconnects", int'(chanConnect), 0);
    irqN = 4'b0110;
    repeat (4) @(posedge clk);
    busStart();
    sendByte(8'hEB, 1, ~1'b1, a);
    readByte(8'h90, 0, got);
    check(got == 8'h90, "R8 R7 stored bits zero after reset", int'(got), 'h90);
    busStop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule